// File: doc/BRIEF.md
# Mixed-Page-Size Translation Lookaside Buffer

This block holds a small, fully associative set of address translations and turns an effective address into a real address. Each entry stores its own page-size code, so 1 KB, 4 KB, 16 KB, 512 KB and 8 MB pages can sit side by side. All entries are compared at once. The compare covers only the address bits above each entry's own page size. On a hit, the block returns the spliced real address together with two region attributes: cacheable and write-through. The cache controller uses these to decide how to service the access.

On a miss, the lookup stalls and the block raises a tablewalk request. An external walker then writes one entry through the refill port. The refill goes to the lowest-numbered invalid entry, or to a round-robin victim when every entry is valid. The held lookup retries on the cycle after the refill. A single-cycle invalidate-all input empties the buffer.

The controller has three states: `S_IDLE`, `S_WAIT` and `S_RETRY`. The transitions are:

- `S_IDLE` to `S_IDLE`: no lookup is presented, or the lookup hits.
- `S_IDLE` to `S_WAIT`: a lookup misses.
- `S_WAIT` to `S_RETRY`: a refill is accepted.
- `S_RETRY` to `S_IDLE`: the retried lookup hits, or the lookup request has been withdrawn.
- `S_RETRY` to `S_WAIT`: the retried lookup misses again.

The requester must hold `lkp_valid` and `lkp_ea` steady until `lkp_done` is seen.

Top module: `tlb_mps`

## Requirements
- R1: After reset no entry is valid, and `lkp_done`, `busy` and `walk_req` are all 0.
- R2: A lookup that hits while the controller is idle asserts `lkp_done` in the same cycle. The real address is formed from the entry's real base above the page offset and the effective address below it. The offset width follows the size code: 0 means 10 bits, 1 means 12, 2 means 14, 3 means 19 and 4 means 23.
- R3: On a hit, `lkp_cache` and `lkp_wthru` equal the cacheable and write-through flags stored with the matching entry.
- R4: Only address bits at or above an entry's page offset take part in the compare, including the stored tag's bits. Every address inside the page hits, and the first address past the page misses.
- R5: When several entries match, the lowest-numbered one supplies the result.
- R6: A lookup that misses in `S_IDLE` leaves `lkp_done` low. From the next cycle, `walk_req` and `busy` are 1, and they stay 1 until a refill is accepted.
- R7: When a refill is accepted in `S_WAIT`, the held lookup completes with `lkp_done` in the following cycle, provided the refilled page covers it.
- R8: A refill is written into the lowest-numbered invalid entry whenever at least one entry is invalid.
- R9: When all entries are valid, a refill replaces the entry named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, after each such replacement.
- R10: `inv_all` clears every valid bit in one cycle. A refill presented in the same cycle is dropped.
- R11: If the retried lookup still misses, `lkp_done` stays low and `busy` stays high, `walk_req` is 0 in the retry cycle, and the controller raises `walk_req` again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear all entries this cycle |
| lkp_valid | input | 1 | Lookup request, held until `lkp_done` |
| lkp_ea | input | ADDR_W | Effective address to translate |
| lkp_done | output | 1 | Lookup completed with a hit this cycle |
| lkp_ra | output | ADDR_W | Translated real address |
| lkp_cache | output | 1 | Region is cacheable |
| lkp_wthru | output | 1 | Region is write-through (0: copy-back) |
| busy | output | 1 | Lookup stalled on a miss |
| walk_req | output | 1 | Tablewalk request |
| fill_valid | input | 1 | Refill write strobe |
| fill_ea | input | ADDR_W | Effective page address of the new entry |
| fill_ra | input | ADDR_W | Real page base of the new entry |
| fill_size | input | 3 | Page-size code (0..4; codes 5..7 act as 1 KB) |
| fill_cache | input | 1 | Cacheable flag of the new entry |
| fill_wthru | input | 1 | Write-through flag of the new entry |

## Verification
The bench builds the block with `ENTRIES` set to 4 and `ADDR_W` at 32. With four entries, the buffer fills after a handful of refills. This brings the round-robin pointer's advance and its wrap within reach in a short run. It also allows the pointer to be parked at a known slot before an invalidate-all. That makes first-invalid allocation distinguishable from pointer allocation through the priority order of overlapping pages. All five size codes appear in the stored entries, and both the 8 MB and 1 KB page boundaries are probed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [2:0] {
        PG_1K   = 3'd0,
        PG_4K   = 3'd1,
        PG_16K  = 3'd2,
        PG_512K = 3'd3,
        PG_8M   = 3'd4
    } pg_size_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_RETRY = 2'd2
    } tlb_state_e;

    // Number of untranslated low address bits for a size code.
    function automatic logic [4:0] pg_off_bits(input logic [2:0] code);
        unique case (code)
            PG_4K:   pg_off_bits = 5'd12;
            PG_16K:  pg_off_bits = 5'd14;
            PG_512K: pg_off_bits = 5'd19;
            PG_8M:   pg_off_bits = 5'd23;
            default: pg_off_bits = 5'd10;
        endcase
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             inv_all,
    input  logic                             fill_valid,
    input  logic [ADDR_W-1:0]                fill_ea,
    input  logic [ADDR_W-1:0]                fill_ra,
    input  logic [2:0]                       fill_size,
    input  logic                             fill_cache,
    input  logic                             fill_wthru,
    output logic                             fill_accept,
    output logic [ENTRIES-1:0]               ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_tag,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_ra,
    output logic [ENTRIES-1:0][2:0]          ent_size,
    output logic [ENTRIES-1:0]               ent_cache,
    output logic [ENTRIES-1:0]               ent_wthru
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] victim;
    logic             any_free;

    assign fill_accept = fill_valid && !inv_all;

    // Lowest invalid slot first, round-robin pointer otherwise.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        victim = any_free ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            rr_ptr    <= '0;
        end else if (inv_all) begin
            ent_valid <= '0;
        end else if (fill_valid) begin
            ent_valid[victim] <= 1'b1;
            if (!any_free) begin
                rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_accept) begin
            ent_tag[victim]   <= fill_ea;
            ent_ra[victim]    <= fill_ra;
            ent_size[victim]  <= fill_size;
            ent_cache[victim] <= fill_cache;
            ent_wthru[victim] <= fill_wthru;
        end
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32
) (
    input  logic [ADDR_W-1:0]                ea,
    input  logic [ENTRIES-1:0]               ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   ent_tag,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   ent_ra,
    input  logic [ENTRIES-1:0][2:0]          ent_size,
    input  logic [ENTRIES-1:0]               ent_cache,
    input  logic [ENTRIES-1:0]               ent_wthru,
    output logic                             hit,
    output logic [ENTRIES-1:0]               hit_sel,
    output logic [ADDR_W-1:0]                ra,
    output logic                             cache,
    output logic                             wthru
);
    logic [ENTRIES-1:0][ADDR_W-1:0] page_mask;
    logic [ENTRIES-1:0]             match;

    // One masked comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        always_comb begin
            page_mask[g] = {ADDR_W{1'b1}} << pg_off_bits(ent_size[g]);
            match[g]     = ent_valid[g] &&
                           (((ea ^ ent_tag[g]) & page_mask[g]) == '0);
        end
    end

    // Lowest index wins.
    always_comb begin
        hit_sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_sel    = '0;
                hit_sel[i] = 1'b1;
            end
        end
    end

    always_comb begin
        hit   = |match;
        ra    = '0;
        cache = 1'b0;
        wthru = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_sel[i]) begin
                ra    = ra | (ent_ra[i] & page_mask[i]) | (ea & ~page_mask[i]);
                cache = cache | ent_cache[i];
                wthru = wthru | ent_wthru[i];
            end
        end
    end

endmodule

// File: rtl/tlb_fsm.sv
module tlb_fsm
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lkp_valid,
    input  logic hit,
    input  logic fill_accept,
    output logic lkp_done,
    output logic busy,
    output logic walk_req
);
    tlb_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (lkp_valid && !hit) state_nx = S_WAIT;
            S_WAIT:  if (fill_accept)       state_nx = S_RETRY;
            S_RETRY: state_nx = (!lkp_valid || hit) ? S_IDLE : S_WAIT;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        lkp_done = 1'b0;
        busy     = 1'b0;
        walk_req = 1'b0;
        unique case (state)
            S_IDLE:  lkp_done = lkp_valid && hit;
            S_WAIT:  begin
                busy     = 1'b1;
                walk_req = 1'b1;
            end
            S_RETRY: begin
                lkp_done = lkp_valid && hit;
                busy     = lkp_valid && !hit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tlb_mps.sv
module tlb_mps #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_ea,
    output logic              lkp_done,
    output logic [ADDR_W-1:0] lkp_ra,
    output logic              lkp_cache,
    output logic              lkp_wthru,
    output logic              busy,
    output logic              walk_req,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_ea,
    input  logic [ADDR_W-1:0] fill_ra,
    input  logic [2:0]        fill_size,
    input  logic              fill_cache,
    input  logic              fill_wthru
);
    logic                           fill_accept;
    logic                           hit;
    logic [ENTRIES-1:0]             hit_sel;
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_ra;
    logic [ENTRIES-1:0][2:0]        ent_size;
    logic [ENTRIES-1:0]             ent_cache;
    logic [ENTRIES-1:0]             ent_wthru;

    tlb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .fill_valid(fill_valid), .fill_ea(fill_ea), .fill_ra(fill_ra),
        .fill_size(fill_size), .fill_cache(fill_cache), .fill_wthru(fill_wthru),
        .fill_accept(fill_accept),
        .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_ra(ent_ra),
        .ent_size(ent_size), .ent_cache(ent_cache), .ent_wthru(ent_wthru)
    );

    tlb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .ea(lkp_ea),
        .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_ra(ent_ra),
        .ent_size(ent_size), .ent_cache(ent_cache), .ent_wthru(ent_wthru),
        .hit(hit), .hit_sel(hit_sel),
        .ra(lkp_ra), .cache(lkp_cache), .wthru(lkp_wthru)
    );

    tlb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .hit(hit),
        .fill_accept(fill_accept),
        .lkp_done(lkp_done), .busy(busy), .walk_req(walk_req)
    );

endmodule

// File: rtl/tlb_mps_chk.sv
module tlb_mps_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lkp_valid,
    input logic               lkp_done,
    input logic               walk_req,
    input logic               busy,
    input logic               fill_valid,
    input logic               inv_all,
    input logic [ENTRIES-1:0] hit_sel
);
    // R2: completion only answers a presented lookup
    p_done_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_done |-> lkp_valid);

    // R5: at most one entry is selected
    p_single_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_sel));

    // R6: no completion while a walk is outstanding, and the stall is reported
    p_walk_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (!lkp_done && busy));

    // R6: the request holds until a refill is accepted
    p_walk_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !(fill_valid && !inv_all)) |=> walk_req);

    // R7: an accepted refill ends the request for the retry cycle
    p_retry_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid && !inv_all) |=> !walk_req);

    // R10: nothing can hit in the cycle after an invalidate-all
    p_inv_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !lkp_done);

endmodule

bind tlb_mps tlb_mps_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_done(lkp_done),
    .walk_req(walk_req), .busy(busy), .fill_valid(fill_valid),
    .inv_all(inv_all), .hit_sel(hit_sel)
);

// File: tb/sim_tlb_mps.sv
`timescale 1ns/1ps
module sim_tlb_mps;
    localparam int ENTRIES = 4;
    localparam int ADDR_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inv_all = 1'b0;
    logic              lkp_valid = 1'b0;
    logic [ADDR_W-1:0] lkp_ea = '0;
    logic              lkp_done;
    logic [ADDR_W-1:0] lkp_ra;
    logic              lkp_cache;
    logic              lkp_wthru;
    logic              busy;
    logic              walk_req;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_ea = '0;
    logic [ADDR_W-1:0] fill_ra = '0;
    logic [2:0]        fill_size = '0;
    logic              fill_cache = 1'b0;
    logic              fill_wthru = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    logic [ADDR_W+1:0] exp_q[$];
    string             req_q[$];

    always #2 clk = ~clk;

    tlb_mps #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lkp_valid(lkp_valid), .lkp_ea(lkp_ea),
        .lkp_done(lkp_done), .lkp_ra(lkp_ra), .lkp_cache(lkp_cache),
        .lkp_wthru(lkp_wthru), .busy(busy), .walk_req(walk_req),
        .fill_valid(fill_valid), .fill_ea(fill_ea), .fill_ra(fill_ra),
        .fill_size(fill_size), .fill_cache(fill_cache), .fill_wthru(fill_wthru)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every completion is compared with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && lkp_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected completion", {30'd0, lkp_ra, lkp_cache, lkp_wthru}, 64'd0);
            end else begin
                logic [ADDR_W+1:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk({lkp_ra, lkp_cache, lkp_wthru} == e, r,
                    {30'd0, lkp_ra, lkp_cache, lkp_wthru}, {30'd0, e});
            end
        end
    end

    task automatic expect_res(input logic [ADDR_W-1:0] ra, input bit c,
                              input bit wt, input string r);
        exp_q.push_back({ra, c, wt});
        req_q.push_back(r);
    endtask

    task automatic drv_start(input logic [ADDR_W-1:0] ea);
        @(posedge clk); #1;
        lkp_valid = 1'b1;
        lkp_ea    = ea;
    endtask

    task automatic drv_stop();
        @(posedge clk); #1;
        lkp_valid = 1'b0;
    endtask

    task automatic wait_done(input string r);
        bit seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (lkp_done) begin
                seen = 1'b1;
                break;
            end
        end
        chk(seen, r, 64'(seen), 64'd1);
    endtask

    task automatic hit_lookup(input logic [ADDR_W-1:0] ea, input logic [ADDR_W-1:0] ra,
                              input bit c, input bit wt, input string r);
        expect_res(ra, c, wt, r);
        drv_start(ea);
        wait_done(r);
        drv_stop();
    endtask

    task automatic refill(input logic [ADDR_W-1:0] tag, input logic [ADDR_W-1:0] ra,
                          input logic [2:0] sz, input bit c, input bit wt);
        @(posedge clk); #1;
        fill_valid = 1'b1;
        fill_ea    = tag;
        fill_ra    = ra;
        fill_size  = sz;
        fill_cache = c;
        fill_wthru = wt;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    // Present a lookup expected to miss; check the stall handshake.
    task automatic miss_start(input logic [ADDR_W-1:0] ea, input string r);
        drv_start(ea);
        @(negedge clk);
        chk(!lkp_done && !walk_req, {r, " R6 miss cycle"}, {lkp_done, walk_req}, 64'd0);
        @(negedge clk);
        chk(walk_req && busy, {r, " R6 walk raised"}, {walk_req, busy}, 64'd3);
    endtask

    // After a refill, completion must come in the next cycle.
    task automatic retry_done(input string r);
        @(negedge clk);
        chk(lkp_done, {r, " R7 retry completes"}, 64'(lkp_done), 64'd1);
        drv_stop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            chk(1'b0, "watchdog expired", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!lkp_done && !busy && !walk_req, "R1 reset outputs",
            {lkp_done, busy, walk_req}, 64'd0);

        // R1: empty after reset, so the first lookup misses. 1 KB page -> entry 0.
        expect_res(32'hABCD_E278, 1'b1, 1'b0, "R7 1K refill result");
        miss_start(32'h1234_5678, "R1");
        @(posedge clk); #1;
        @(negedge clk);
        chk(walk_req && busy, "R6 request held", {walk_req, busy}, 64'd3);
        refill(32'h1234_5400, 32'hABCD_E000, 3'd0, 1'b1, 1'b0);
        retry_done("R7");

        // R2/R3/R4: other address in the same 1 KB page
        hit_lookup(32'h1234_57FC, 32'hABCD_E3FC, 1'b1, 1'b0, "R2 R3 1K hit");

        // R4: 8 MB page whose stored tag carries junk low bits -> entry 1
        expect_res(32'h8065_4321, 1'b0, 1'b1, "R4 8M refill result");
        miss_start(32'h0765_4321, "R4");
        refill(32'h0712_3456, 32'h8000_0000, 3'd4, 1'b0, 1'b1);
        retry_done("R4");
        hit_lookup(32'h077F_FFFF, 32'h807F_FFFF, 1'b0, 1'b1, "R4 8M top of page");

        // R4: first address past the 8 MB page misses; 16 KB refill -> entry 2
        expect_res(32'h0010_0000, 1'b1, 1'b1, "R4 16K refill result");
        miss_start(32'h0780_0000, "R4 past page");
        refill(32'h0780_0000, 32'h0010_0000, 3'd2, 1'b1, 1'b1);
        retry_done("R4");
        hit_lookup(32'h0780_3FFF, 32'h0010_3FFF, 1'b1, 1'b1, "R4 16K top of page");

        // R5: 512 KB page overlapping entry 0 -> entry 3; lowest entry wins
        refill(32'h1230_0000, 32'h4000_0000, 3'd3, 1'b0, 1'b0);
        hit_lookup(32'h1234_5678, 32'hABCD_E278, 1'b1, 1'b0, "R5 lowest entry wins");
        hit_lookup(32'h1230_0010, 32'h4000_0010, 1'b0, 1'b0, "R5 only 512K matches");

        // R9: all valid, pointer at 0 -> 4 KB page replaces entry 0
        expect_res(32'h6000_0234, 1'b1, 1'b0, "R9 4K refill result");
        miss_start(32'h5000_1234, "R9");
        refill(32'h5000_1000, 32'h6000_0000, 3'd1, 1'b1, 1'b0);
        retry_done("R9");
        hit_lookup(32'h1234_5678, 32'h4004_5678, 1'b0, 1'b0, "R9 entry 0 was the victim");

        // R9: pointer now 1 -> evicts the 8 MB entry
        refill(32'h9000_0000, 32'h1111_1000, 3'd0, 1'b0, 1'b0);

        // R11: retry with an unrelated refill misses again
        expect_res(32'h8065_4321, 1'b0, 1'b1, "R11 final result");
        miss_start(32'h0765_4321, "R9 evicted page");
        refill(32'hA000_0000, 32'h2222_2000, 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        chk(!lkp_done && busy && !walk_req, "R11 retry still missing",
            {lkp_done, busy, walk_req}, 64'd2);
        @(negedge clk);
        chk(walk_req, "R11 walk raised again", 64'(walk_req), 64'd1);
        refill(32'h0700_0000, 32'h8000_0000, 3'd4, 1'b0, 1'b1);
        retry_done("R11");

        // Pointer wrapped to 0; two more refills park it at 2
        refill(32'hB000_0000, 32'h3333_3000, 3'd0, 1'b0, 1'b0);
        refill(32'hC000_0000, 32'h4444_4000, 3'd0, 1'b0, 1'b0);

        // R10: invalidate all; a present page now misses
        @(posedge clk); #1 inv_all = 1'b1;
        @(posedge clk); #1 inv_all = 1'b0;
        expect_res(32'h2000_0004, 1'b1, 1'b1, "R10 refill after clear");
        miss_start(32'hB000_0004, "R10 cleared entry misses");
        @(posedge clk); #1;
        fill_valid = 1'b1;
        inv_all    = 1'b1;
        fill_ea    = 32'hB000_0000;
        fill_ra    = 32'h2000_0000;
        fill_size  = 3'd0;
        fill_cache = 1'b1;
        fill_wthru = 1'b1;
        @(posedge clk); #1;
        fill_valid = 1'b0;
        inv_all    = 1'b0;
        @(negedge clk);
        chk(walk_req && !lkp_done, "R10 refill with clear dropped", {walk_req, lkp_done}, 64'd2);
        @(negedge clk);
        chk(walk_req, "R10 still waiting", 64'(walk_req), 64'd1);
        refill(32'hB000_0000, 32'h2000_0000, 3'd0, 1'b1, 1'b1);
        retry_done("R10");

        // R8: first invalid slots, not the pointer, receive the next refills
        refill(32'h1234_5400, 32'hABCD_E000, 3'd0, 1'b1, 1'b0);
        refill(32'h1230_0000, 32'h4000_0000, 3'd3, 1'b0, 1'b0);
        hit_lookup(32'h1234_5678, 32'hABCD_E278, 1'b1, 1'b0, "R8 first invalid allocation order");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected results seen", 64'(exp_q.size()), 64'd0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule